// File: doc/BRIEF.md
# Differential Frame-Header Correlator

This block searches a received complex symbol stream for a known frame header. It takes one signed I/Q sample per symbol and multiplies each sample by the complex conjugate of the sample before it. This differential product removes the absolute carrier phase, and a frequency offset that rotates the constellation by a constant step per symbol only turns the product by a fixed angle. The products pass through a delay line whose positions carry fixed weights from {+1, +j, −1, −j}. Each weight is applied with sign flips and I/Q swaps, so the block contains no multipliers.

The header falls into two sections. The older positions belong to the start-of-frame sync pattern and the newer positions to the signalling code. Only every other position of the signalling section holds a known weight. Each section is summed on its own. The two section sums are then added and subtracted, and the metric is the larger magnitude of those two results, so a signalling section of either polarity is found. A following stage compares the metric with a threshold and verifies the peak.

A small fill state machine has two states, FILL and RUN. After reset it sits in FILL and counts accepted samples. On the sample that completes the correlation window it takes the transition FILL→RUN and stays in RUN until the next reset. Results are flagged valid only in RUN and on that transition sample.

Top module: `diff_hdr_corr`

## Requirements
- R1: A synchronous reset clears the delay line, the stored previous sample, `metric`, `out_valid` and `det`, and returns the fill machine to FILL.
- R2: For each accepted sample x with stored previous sample p, the differential is x·conj(p), with the real and imaginary parts each shifted arithmetically right by IQ_W−1 (rounding toward −∞). The first sample after reset uses p = 0.
- R3: The accumulators are wide enough that no input sequence overflows them. `metric` never exceeds 3·LINE_LEN·2^(IQ_W−1), and it is exact for full-scale inputs such as −128.
- R4: Window position k (0 = oldest of the last LINE_LEN differentials) is weighted by the 2-bit code TAP_CODE[2k+1:2k], where 0 = +1, 1 = +j, 2 = −1 and 3 = −j. It contributes only if TAP_MASK[k] is 1. Positions k < SOF_LEN form the sync branch S and the rest form the signalling branch P.
- R5: `metric` = max(mag(S+P), mag(S−P)), with mag(a+jb) = max(|a|,|b|) + floor(min(|a|,|b|)/2).
- R6: A header whose signalling differentials are all negated still drives `metric` above the threshold used for the upright header.
- R7: A header received with a constant 90° phase advance per symbol still drives `metric` above the same threshold.
- R8: `metric`, `out_valid` and `det` are registered one cycle after each sample with `in_valid` high. A cycle with `in_valid` low gives `out_valid` = 0 on the next cycle and leaves `metric` unchanged.
- R9: `out_valid` stays 0 until LINE_LEN samples have been accepted since reset. It is 1 for the LINE_LEN-th accepted sample and for every later one.
- R10: `det` is 1 exactly when `out_valid` is 1 and `metric` is strictly greater than the `thresh` value presented with the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_i | input | IQ_W | Sample in-phase part, signed |
| in_q | input | IQ_W | Sample quadrature part, signed |
| thresh | input | ACC_W | Detection threshold, unsigned |
| out_valid | output | 1 | Metric covers a full window |
| metric | output | ACC_W | Correlation magnitude, unsigned |
| det | output | 1 | Metric above threshold |

## Verification
A random full-range stream, compared sample by sample against an arithmetic model, separates errors in the differential product, the tap decoding and the section boundary. Full-scale corner values show overflow or a wrong scaling shift. A header built from the taps themselves is sent three ways: upright, with its signalling section negated, and rotated by 90° per symbol. These distinguish the sum path from the difference path and confirm the phase tolerance. The threshold is then set exactly at the peak metric and one below it to pin the strict comparison, and idle gaps and a reset in mid-stream exercise the hold behaviour and the fill count.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
    localparam int HDR_LEN = 89;
    localparam int HDR_SOF = 25;

    typedef enum logic [1:0] {
        TAP_P1 = 2'd0,
        TAP_PJ = 2'd1,
        TAP_M1 = 2'd2,
        TAP_MJ = 2'd3
    } tap_e;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;

    // Default weights: a pseudo-random walk over the four unit values
    function automatic logic [2*HDR_LEN-1:0] gen_codes();
        logic [7:0]           lf;
        logic [2*HDR_LEN-1:0] v;
        lf = 8'hA5;
        v  = '0;
        for (int k = 0; k < HDR_LEN; k++) begin
            v[2*k +: 2] = lf[1:0];
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        end
        return v;
    endfunction

    // Sync section fully known, signalling section known at every other slot
    function automatic logic [HDR_LEN-1:0] gen_mask();
        logic [HDR_LEN-1:0] v;
        v = '0;
        for (int k = 0; k < HDR_LEN; k++)
            v[k] = (k < HDR_SOF) || (((k - HDR_SOF) % 2) == 1);
        return v;
    endfunction

    localparam logic [2*HDR_LEN-1:0] DEF_CODES = gen_codes();
    localparam logic [HDR_LEN-1:0]   DEF_MASK  = gen_mask();
endpackage

// File: rtl/dhc_diff.sv
module dhc_diff #(
    parameter int IQ_W   = 8,
    parameter int DIFF_W = IQ_W + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [IQ_W-1:0]   in_i,
    input  logic signed [IQ_W-1:0]   in_q,
    output logic signed [DIFF_W-1:0] d_i,
    output logic signed [DIFF_W-1:0] d_q
);
    localparam int PROD_W = 2 * IQ_W + 1;

    logic signed [IQ_W-1:0]   prev_i, prev_q;
    logic signed [PROD_W-1:0] re_full, im_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_i <= '0;
            prev_q <= '0;
        end else if (in_valid) begin
            prev_i <= in_i;
            prev_q <= in_q;
        end
    end

    // x * conj(p) = (xi*pi + xq*pq) + j(xq*pi - xi*pq)
    always_comb begin
        re_full = PROD_W'(in_i) * PROD_W'(prev_i) + PROD_W'(in_q) * PROD_W'(prev_q);
        im_full = PROD_W'(in_q) * PROD_W'(prev_i) - PROD_W'(in_i) * PROD_W'(prev_q);
        d_i     = DIFF_W'(re_full >>> (IQ_W - 1));
        d_q     = DIFF_W'(im_full >>> (IQ_W - 1));
    end
endmodule

// File: rtl/dhc_line.sv
module dhc_line #(
    parameter int DIFF_W   = 10,
    parameter int LINE_LEN = 89
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shift_en,
    input  logic signed [DIFF_W-1:0] new_i,
    input  logic signed [DIFF_W-1:0] new_q,
    output logic signed [DIFF_W-1:0] win_i [LINE_LEN],
    output logic signed [DIFF_W-1:0] win_q [LINE_LEN]
);
    localparam int ST_LEN = LINE_LEN - 1;

    logic signed [DIFF_W-1:0] st_i [ST_LEN];
    logic signed [DIFF_W-1:0] st_q [ST_LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ST_LEN; k++) begin
                st_i[k] <= '0;
                st_q[k] <= '0;
            end
        end else if (shift_en) begin
            for (int k = 0; k < ST_LEN - 1; k++) begin
                st_i[k] <= st_i[k+1];
                st_q[k] <= st_q[k+1];
            end
            st_i[ST_LEN-1] <= new_i;
            st_q[ST_LEN-1] <= new_q;
        end
    end

    // Oldest first; the newest position is the incoming differential
    for (genvar k = 0; k < ST_LEN; k++) begin : g_win
        assign win_i[k] = st_i[k];
        assign win_q[k] = st_q[k];
    end
    assign win_i[LINE_LEN-1] = new_i;
    assign win_q[LINE_LEN-1] = new_q;
endmodule

// File: rtl/dhc_branch.sv
module dhc_branch #(
    parameter int                    DIFF_W   = 10,
    parameter int                    ACC_W    = 17,
    parameter int                    LINE_LEN = 89,
    parameter int                    LO       = 0,
    parameter int                    HI       = 25,
    parameter logic [2*LINE_LEN-1:0] TAP_CODE = '0,
    parameter logic [LINE_LEN-1:0]   TAP_MASK = '0
) (
    input  logic signed [DIFF_W-1:0] win_i [LINE_LEN],
    input  logic signed [DIFF_W-1:0] win_q [LINE_LEN],
    output logic signed [ACC_W-1:0]  sum_i,
    output logic signed [ACC_W-1:0]  sum_q
);
    import dhc_pkg::*;

    logic signed [ACC_W-1:0] xi, xq;

    always_comb begin
        sum_i = '0;
        sum_q = '0;
        xi    = '0;
        xq    = '0;
        for (int k = LO; k < HI; k++) begin
            if (TAP_MASK[k]) begin
                xi = ACC_W'(win_i[k]);
                xq = ACC_W'(win_q[k]);
                unique case (tap_e'(TAP_CODE[2*k +: 2]))
                    TAP_P1: begin sum_i = sum_i + xi; sum_q = sum_q + xq; end
                    TAP_PJ: begin sum_i = sum_i - xq; sum_q = sum_q + xi; end
                    TAP_M1: begin sum_i = sum_i - xi; sum_q = sum_q - xq; end
                    TAP_MJ: begin sum_i = sum_i + xq; sum_q = sum_q - xi; end
                endcase
            end
        end
    end
endmodule

// File: rtl/dhc_combine.sv
module dhc_combine #(
    parameter int ACC_W = 17
) (
    input  logic signed [ACC_W-1:0] s_i,
    input  logic signed [ACC_W-1:0] s_q,
    input  logic signed [ACC_W-1:0] p_i,
    input  logic signed [ACC_W-1:0] p_q,
    output logic        [ACC_W-1:0] metric
);
    function automatic logic [ACC_W-1:0] mag(input logic signed [ACC_W-1:0] a,
                                             input logic signed [ACC_W-1:0] b);
        logic [ACC_W-1:0] aa, ab, hi, lo;
        aa = (a < 0) ? ACC_W'(-a) : ACC_W'(a);
        ab = (b < 0) ? ACC_W'(-b) : ACC_W'(b);
        hi = (aa > ab) ? aa : ab;
        lo = (aa > ab) ? ab : aa;
        return hi + (lo >> 1);
    endfunction

    logic [ACC_W-1:0] m_add, m_sub;

    always_comb begin
        m_add  = mag(s_i + p_i, s_q + p_q);
        m_sub  = mag(s_i - p_i, s_q - p_q);
        metric = (m_add > m_sub) ? m_add : m_sub;
    end
endmodule

// File: rtl/diff_hdr_corr.sv
module diff_hdr_corr #(
    parameter int                    IQ_W     = 8,
    parameter int                    LINE_LEN = dhc_pkg::HDR_LEN,
    parameter int                    SOF_LEN  = dhc_pkg::HDR_SOF,
    parameter logic [2*LINE_LEN-1:0] TAP_CODE = dhc_pkg::DEF_CODES,
    parameter logic [LINE_LEN-1:0]   TAP_MASK = dhc_pkg::DEF_MASK,
    localparam int DIFF_W = IQ_W + 2,
    localparam int ACC_W  = DIFF_W + $clog2(LINE_LEN)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IQ_W-1:0] in_i,
    input  logic signed [IQ_W-1:0] in_q,
    input  logic [ACC_W-1:0]       thresh,
    output logic                   out_valid,
    output logic [ACC_W-1:0]       metric,
    output logic                   det
);
    import dhc_pkg::*;

    localparam int CNT_W = $clog2(LINE_LEN + 1);

    logic signed [DIFF_W-1:0] d_i, d_q;
    logic signed [DIFF_W-1:0] win_i [LINE_LEN];
    logic signed [DIFF_W-1:0] win_q [LINE_LEN];
    logic signed [ACC_W-1:0]  s_i, s_q, p_i, p_q;
    logic [ACC_W-1:0]         metric_c;

    fill_state_e      state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             win_full;

    dhc_diff #(.IQ_W(IQ_W), .DIFF_W(DIFF_W)) u_diff (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .d_i(d_i), .d_q(d_q)
    );

    dhc_line #(.DIFF_W(DIFF_W), .LINE_LEN(LINE_LEN)) u_line (
        .clk(clk), .rst(rst), .shift_en(in_valid),
        .new_i(d_i), .new_q(d_q), .win_i(win_i), .win_q(win_q)
    );

    dhc_branch #(
        .DIFF_W(DIFF_W), .ACC_W(ACC_W), .LINE_LEN(LINE_LEN),
        .LO(0), .HI(SOF_LEN), .TAP_CODE(TAP_CODE), .TAP_MASK(TAP_MASK)
    ) u_sync (
        .win_i(win_i), .win_q(win_q), .sum_i(s_i), .sum_q(s_q)
    );

    dhc_branch #(
        .DIFF_W(DIFF_W), .ACC_W(ACC_W), .LINE_LEN(LINE_LEN),
        .LO(SOF_LEN), .HI(LINE_LEN), .TAP_CODE(TAP_CODE), .TAP_MASK(TAP_MASK)
    ) u_sig (
        .win_i(win_i), .win_q(win_q), .sum_i(p_i), .sum_q(p_q)
    );

    dhc_combine #(.ACC_W(ACC_W)) u_comb (
        .s_i(s_i), .s_q(s_q), .p_i(p_i), .p_q(p_q), .metric(metric_c)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FILL;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next state: FILL counts accepted samples, FILL->RUN on the window-completing one
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        win_full = 1'b0;
        unique case (state)
            ST_FILL: begin
                win_full = (cnt == CNT_W'(LINE_LEN - 1));
                if (in_valid) begin
                    cnt_nx = cnt + 1'b1;
                    if (win_full)
                        state_nx = ST_RUN;
                end
            end
            ST_RUN: win_full = 1'b1;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            det       <= 1'b0;
            metric    <= '0;
        end else begin
            out_valid <= in_valid && win_full;
            det       <= in_valid && win_full && (metric_c > thresh);
            if (in_valid)
                metric <= metric_c;
        end
    end
endmodule

// File: rtl/dhc_checker.sv
module dhc_checker #(
    parameter int IQ_W     = 8,
    parameter int LINE_LEN = 89,
    parameter int ACC_W    = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [ACC_W-1:0] thresh,
    input logic             out_valid,
    input logic [ACC_W-1:0] metric,
    input logic             det
);
    localparam int CNT_W = $clog2(LINE_LEN + 1);
    localparam int LIMIT = 3 * LINE_LEN * (2 ** (IQ_W - 1));

    logic [CNT_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)
            seen <= '0;
        else if (in_valid && (seen < CNT_W'(LINE_LEN)))
            seen <= seen + 1'b1;
    end

    // R8: a result only follows an accepted sample
    a_r8_valid_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R8: metric holds across a cycle without input
    a_r8_metric_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> $stable(metric));

    // R9: valid exactly once the window holds LINE_LEN accepted samples
    a_r9_fill_window: assert property (@(posedge clk) disable iff (rst)
        out_valid == ($past(in_valid) && (seen >= CNT_W'(LINE_LEN))));

    // R10: strict threshold compare on valid results
    a_r10_det_strict: assert property (@(posedge clk) disable iff (rst)
        det == (out_valid && (metric > $past(thresh))));

    // R3: metric stays within the accumulator bound
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        metric <= ACC_W'(LIMIT));
endmodule

bind diff_hdr_corr dhc_checker #(
    .IQ_W(IQ_W), .LINE_LEN(LINE_LEN), .ACC_W(ACC_W)
) u_dhc_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .thresh(thresh),
    .out_valid(out_valid), .metric(metric), .det(det)
);

// File: tb/diff_hdr_corr_bench.sv
`timescale 1ns/1ps
module diff_hdr_corr_bench;
    localparam int                 IQ_W   = 8;
    localparam int                 L      = 13;
    localparam int                 S      = 5;
    localparam logic [2*L-1:0]     CODES  = 26'h2C6B1E4;
    localparam logic [L-1:0]       MASK   = 13'h155F;
    localparam int                 ACC_W  = IQ_W + 2 + $clog2(L);

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic signed [IQ_W-1:0] in_i = '0;
    logic signed [IQ_W-1:0] in_q = '0;
    logic [ACC_W-1:0]       thresh = '0;
    logic                   out_valid;
    logic [ACC_W-1:0]       metric;
    logic                   det;

    always #10 clk = ~clk;

    diff_hdr_corr #(
        .IQ_W(IQ_W), .LINE_LEN(L), .SOF_LEN(S), .TAP_CODE(CODES), .TAP_MASK(MASK)
    ) u_diff_hdr_corr (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .thresh(thresh), .out_valid(out_valid), .metric(metric), .det(det)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int hi [L];
    int hq [L];
    int pi_m, pq_m, nacc, exp_m, held_m;
    bit exp_v;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int mag(int a, int b);
        int x, y;
        x = iabs(a);
        y = iabs(b);
        return (x > y) ? x + y / 2 : y + x / 2;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < L; k++) begin hi[k] = 0; hq[k] = 0; end
        pi_m = 0; pq_m = 0; nacc = 0; exp_m = 0; held_m = 0; exp_v = 1'b0;
    endtask

    task automatic model_push(int a, int b);
        int re, im, si, sq, qi, qq, ti, tq, ma, mb;
        re = (a * pi_m + b * pq_m) >>> (IQ_W - 1);
        im = (b * pi_m - a * pq_m) >>> (IQ_W - 1);
        for (int k = 0; k < L - 1; k++) begin hi[k] = hi[k+1]; hq[k] = hq[k+1]; end
        hi[L-1] = re; hq[L-1] = im;
        pi_m = a; pq_m = b; nacc++;
        si = 0; sq = 0; qi = 0; qq = 0;
        for (int k = 0; k < L; k++) begin
            if (MASK[k]) begin
                case (CODES[2*k +: 2])
                    2'd0: begin ti = hi[k];  tq = hq[k];  end
                    2'd1: begin ti = -hq[k]; tq = hi[k];  end
                    2'd2: begin ti = -hi[k]; tq = -hq[k]; end
                    default: begin ti = hq[k]; tq = -hi[k]; end
                endcase
                if (k < S) begin si += ti; sq += tq; end
                else       begin qi += ti; qq += tq; end
            end
        end
        ma = mag(si + qi, sq + qq);
        mb = mag(si - qi, sq - qq);
        exp_m = (ma > mb) ? ma : mb;
        held_m = exp_m;
        exp_v = (nacc >= L);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "det", int'(det), 0);
        chk("R1", "metric", int'(metric), 0);
        rst = 1'b0;
        model_reset();
    endtask

    // Called at a negedge; drives one sample, checks results one cycle later
    task automatic send(int a, int b, string tag);
        in_valid = 1'b1;
        in_i = IQ_W'(a);
        in_q = IQ_W'(b);
        model_push(a, b);
        @(negedge clk);
        chk("R9", "out_valid", int'(out_valid), int'(exp_v));
        chk(tag, "metric", int'(metric), exp_m);
        chk("R10", "det", int'(det), int'(exp_v && (exp_m > int'(thresh))));
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            chk("R8", "out_valid idle", int'(out_valid), 0);
            chk("R8", "metric held", int'(metric), held_m);
        end
    endtask

    function automatic int rnd();
        return int'($urandom_range(255)) - 128;
    endfunction

    // Multiply a unit-grid sample by a weight code (0:+1 1:+j 2:-1 3:-j)
    task automatic rot(inout int xr, inout int xi, input int code);
        int t;
        for (int c = 0; c < code; c++) begin t = xr; xr = -xi; xi = t; end
    endtask

    // Header whose differentials are conj(tap); optional signalling flip and 90 deg/symbol spin
    task automatic run_header(int thr, bit flip, bit spin, string tag);
        int xr, xi, sr, si, code;
        do_reset();
        thresh = ACC_W'(thr);
        for (int f = 0; f < 4; f++) send(rnd(), rnd(), "R2");
        xr = 100; xi = 0;
        send(xr, xi, tag);
        for (int k = 0; k < L; k++) begin
            code = MASK[k] ? ((4 - int'(CODES[2*k +: 2])) % 4) : 0;
            if (flip && k >= S) code = (code + 2) % 4;
            rot(xr, xi, code);
            sr = xr; si = xi;
            if (spin) rot(sr, si, (k + 1) % 4);
            send(sr, si, tag);
        end
    endtask

    initial begin
        int m0;
        void'($urandom(7));
        model_reset();
        // R1 reset state
        do_reset();

        // R9 fill window, then R2/R4/R5 on random full-range data with R8 gaps
        for (int n = 0; n < L + 40; n++) begin
            send(rnd(), rnd(), (n < L) ? "R9" : "R4");
            if (n % 9 == 4) idle(2);
        end

        // R3 full-scale corner values
        for (int n = 0; n < 30; n++) begin
            case (n % 3)
                0: send(-128, -128, "R3");
                1: send(127, -128, "R3");
                default: send(-128, 127, "R3");
            endcase
        end

        // R5 sweep over a grid of amplitudes
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                send(-128 + a * 63, -128 + b * 63, "R5");

        // R1 reset in mid-stream, then R2 first sample uses zero previous
        do_reset();
        for (int n = 0; n < L + 2; n++) send(rnd(), rnd(), "R2");

        // R4 upright header peak
        run_header(600, 1'b0, 1'b0, "R4");
        chk("R4", "det on header", int'(det), 1);
        m0 = exp_m;

        // R10 threshold exactly at the peak, then one below
        run_header(m0, 1'b0, 1'b0, "R10");
        chk("R10", "det at thresh==metric", int'(det), 0);
        run_header(m0 - 1, 1'b0, 1'b0, "R10");
        chk("R10", "det at thresh==metric-1", int'(det), 1);

        // R6 inverted signalling section
        run_header(600, 1'b1, 1'b0, "R6");
        chk("R6", "det flipped", int'(det), 1);

        // R7 90 degree per symbol rotation
        run_header(600, 1'b0, 1'b1, "R7");
        chk("R7", "det spun", int'(det), 1);

        // R8 hold after the last result
        idle(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule